// File: doc/BRIEF.md
# Multi-Mode Timer and Event Counter

This block is an up-counter with a preload register and an 8-bit control register. Software reaches it through a small register bus. The control register picks one of three ways of counting. In event mode the counter steps once for each selected edge on an external input pin. In timer mode it steps once for each cycle in which the internal instruction-clock enable `tick` is high. In pulse-width mode it times how long the external pin stays at a new level, measured in `tick` cycles.

In every mode, counting past the all-ones value reloads the counter from the preload register. The same clock edge also raises an overflow flag. That flag drives the interrupt request when the interrupt enable input is high. In pulse-width mode the block waits for the selected edge on the pin and counts while the pin keeps its new level. When the pin returns to its old level, the block clears its own run bit. The result is then held until software arms the block again.

The external pin passes through a synchronizer before any edge detection. Register reads come back one clock after the address is presented.

Top module: `evtimer_top`

## Requirements
- R1: After reset, the control, preload, counter and flag registers all read 0, and `irq` is low.
- R2: The control register (address 0) reads back as {mode[7:6], 0, run[4], edge[3], 000}. Bits 5 and 2:0 always read 0. Writing 8'hFF reads back as 8'hD8.
- R3: In timer mode (mode 2'b10) with run = 1, the counter (address 2) goes up by one for each cycle in which `tick` is high. With run = 0 it holds its value.
- R4: In event mode (mode 2'b01) with run = 1, the counter goes up by one per edge of the synchronized pin. With edge = 0 it counts low-to-high edges; with edge = 1 it counts high-to-low edges. The opposite edge does not count.
- R5: In event and timer modes, a step from 16'hFFFF loads the preload value and sets the flag (address 3, bit 0) on the same edge. The run bit stays 1.
- R6: A write to the preload register (address 1) while run = 0 also loads the counter. While run = 1 the write changes only the preload register.
- R7: In pulse-width mode (mode 2'b11) with run = 1, the selected edge starts counting `tick` cycles. When the pin returns to its previous level, counting stops, the run bit clears and the count is held.
- R8: After a measurement ends, further pin edges leave the count unchanged until run is written to 1 again. Setting run while the pin already sits at the active level does not start a measurement; only an edge that comes later does.
- R9: An overflow during a pulse-width measurement reloads the counter from the preload register and sets the flag.
- R10: `irq` equals flag AND `int_en`, delayed by one clock. The flag is set whatever the value of `int_en`. Writing 0 to bit 0 of address 3 clears the flag; writing 1 leaves it unchanged.
- R11: With mode 2'b00 the counter does not change, even when run = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Instruction-clock enable used by timer and pulse-width modes |
| ext_pin | input | 1 | Asynchronous external input pin |
| int_en | input | 1 | Interrupt enable; gates `irq` only |
| bus_addr | input | 2 | Register address: 0 control, 1 preload, 2 counter, 3 flag |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data for the address of the previous cycle |
| irq | output | 1 | Interrupt request |

## Verification
A wrong counter value, or a wrong decision to reload, shows up on the next read of address 2. Because the counter advances one step per event, a single missed or extra step leaves a permanent offset in every later read. A measurement that never stops, or a stop that comes early, shows two cycles after the read: the run bit reads back wrong, and the held count drifts while `tick` keeps running. Faults in the flag or in interrupt gating reach `irq` one clock after the flag changes.

// File: rtl/evt_pkg.sv
package evt_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PULSE = 2'b11
  } evt_mode_e;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_PRE  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CNT  = 2'd2;
  localparam logic [ADDR_W-1:0] A_FLAG = 2'd3;

  // control bit positions
  localparam int B_EDGE  = 3;
  localparam int B_RUN   = 4;
  localparam int B_MODE0 = 6;
  localparam int B_MODE1 = 7;

endpackage

// File: rtl/evt_pin_front.sv
module evt_pin_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_async,
  input  logic edge_sel,
  output logic act_edge,
  output logic ret_edge
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= pin_async;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[LAST];
  end

  logic rise, fall;
  always_comb begin
    rise     = sync_q[LAST] & ~prev_q;
    fall     = ~sync_q[LAST] & prev_q;
    act_edge = edge_sel ? fall : rise;
    ret_edge = edge_sel ? rise : fall;
  end

endmodule

// File: rtl/evt_ctrl_regs.sv
module evt_ctrl_regs
  import evt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [CNT_W-1:0]  bus_wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              ovf,
  input  logic              hw_stop,
  input  logic              int_en,
  output evt_mode_e         mode,
  output logic              run,
  output logic              edge_sel,
  output logic [CNT_W-1:0]  preload,
  output logic              flag,
  output logic              irq,
  output logic              cnt_wr,
  output logic              pre_load,
  output logic [CNT_W-1:0]  rdata
);
  logic ctrl_wr, pre_wr, flag_wr;

  always_comb begin
    ctrl_wr  = bus_wr && (bus_addr == A_CTRL);
    pre_wr   = bus_wr && (bus_addr == A_PRE);
    flag_wr  = bus_wr && (bus_addr == A_FLAG);
    cnt_wr   = bus_wr && (bus_addr == A_CNT);
    pre_load = pre_wr && !run;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= MODE_OFF;
      run      <= 1'b0;
      edge_sel <= 1'b0;
    end else if (ctrl_wr) begin
      mode     <= evt_mode_e'(bus_wdata[B_MODE1:B_MODE0]);
      run      <= bus_wdata[B_RUN];
      edge_sel <= bus_wdata[B_EDGE];
    end else if (hw_stop) begin
      run      <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         preload <= '0;
    else if (pre_wr) preload <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)                         flag <= 1'b0;
    else if (ovf)                    flag <= 1'b1;
    else if (flag_wr && !bus_wdata[0]) flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= flag & int_en;
  end

  logic [CNT_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      A_CTRL: begin
        rd_mux[B_MODE1:B_MODE0] = mode;
        rd_mux[B_RUN]           = run;
        rd_mux[B_EDGE]          = edge_sel;
      end
      A_PRE:   rd_mux = preload;
      A_CNT:   rd_mux = cnt;
      default: rd_mux[0] = flag;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

endmodule

// File: rtl/evt_count_core.sv
module evt_count_core
  import evt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  evt_mode_e        mode,
  input  logic             run,
  input  logic             act_edge,
  input  logic             ret_edge,
  input  logic             tick,
  input  logic [CNT_W-1:0] preload,
  input  logic             cnt_wr,
  input  logic             pre_load,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf,
  output logic             hw_stop,
  output logic             meas
);
  logic inc, at_max, bus_load;

  always_comb begin
    unique case (mode)
      MODE_EVENT: inc = run & act_edge;
      MODE_TIMER: inc = run & tick;
      MODE_PULSE: inc = meas & tick & ~ret_edge;
      default:    inc = 1'b0;
    endcase
    at_max   = &cnt;
    bus_load = cnt_wr | pre_load;
    ovf      = inc & at_max & ~bus_load;
    hw_stop  = meas & ret_edge & run & (mode == MODE_PULSE);
  end

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (bus_load) cnt <= wdata;
    else if (inc)      cnt <= at_max ? preload : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !run || mode != MODE_PULSE) meas <= 1'b0;
    else if (!meas && act_edge)            meas <= 1'b1;
    else if (meas && ret_edge)             meas <= 1'b0;
  end

endmodule

// File: rtl/evtimer_top.sv
module evtimer_top
  import evt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              ext_pin,
  input  logic              int_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  evt_mode_e        mode_q;
  logic             run_q, edge_q, flag_q, meas_q;
  logic             act_edge, ret_edge, ovf, hw_stop, cnt_wr, pre_load;
  logic [CNT_W-1:0] preload_q, cnt_q;

  evt_pin_front #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk(clk), .rst(rst), .pin_async(ext_pin), .edge_sel(edge_q),
    .act_edge(act_edge), .ret_edge(ret_edge)
  );

  evt_ctrl_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .cnt(cnt_q), .ovf(ovf), .hw_stop(hw_stop),
    .int_en(int_en), .mode(mode_q), .run(run_q), .edge_sel(edge_q),
    .preload(preload_q), .flag(flag_q), .irq(irq), .cnt_wr(cnt_wr),
    .pre_load(pre_load), .rdata(bus_rdata)
  );

  evt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .mode(mode_q), .run(run_q),
    .act_edge(act_edge), .ret_edge(ret_edge), .tick(tick),
    .preload(preload_q), .cnt_wr(cnt_wr), .pre_load(pre_load),
    .wdata(bus_wdata), .cnt(cnt_q), .ovf(ovf), .hw_stop(hw_stop),
    .meas(meas_q)
  );

endmodule

// File: rtl/evtimer_chk.sv
module evtimer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             int_en,
  input logic             bus_wr,
  input logic [1:0]       mode,
  input logic             run,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] preload,
  input logic             flag,
  input logic             irq,
  input logic             meas
);
  // R3
  timer_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && mode == 2'b10 && tick && !bus_wr && cnt != '1) |=> cnt == $past(cnt) + 1'b1);

  // R5
  ovf_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (run && mode == 2'b10 && tick && !bus_wr && cnt == '1) |=> (cnt == $past(preload) && flag));

  // R5
  run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && (mode == 2'b01 || mode == 2'b10) && !bus_wr) |=> run);

  // R3
  stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !meas && !bus_wr) |=> $stable(cnt));

  // R11
  idle_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 && !bus_wr) |=> $stable(cnt));

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !int_en |=> !irq);

  // R10
  irq_noflag_chk: assert property (@(posedge clk) disable iff (rst)
    !flag |=> !irq);

endmodule

bind evtimer_top evtimer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .int_en(int_en), .bus_wr(bus_wr),
  .mode(mode_q), .run(run_q), .cnt(cnt_q), .preload(preload_q),
  .flag(flag_q), .irq(irq), .meas(meas_q)
);

// File: tb/evtimer_top_bench.sv
`timescale 1ns/1ps
module evtimer_top_bench;
  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_T = 2'd2;
  localparam logic [1:0] AC = 2'd0, AP = 2'd1, AN = 2'd2, AF = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  addr;
    logic [15:0] data;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{OP_W, AC, 16'h00FF, 16'h0000, 4'd2},
    '{OP_R, AC, 16'h0000, 16'h00D8, 4'd2},  // R2 unused bits read 0
    '{OP_W, AC, 16'h0000, 16'h0000, 4'd2},
    '{OP_W, AP, 16'h1234, 16'h0000, 4'd6},
    '{OP_R, AN, 16'h0000, 16'h1234, 4'd6},  // R6 stopped: counter loaded
    '{OP_R, AP, 16'h0000, 16'h1234, 4'd6},
    '{OP_W, AC, 16'h0090, 16'h0000, 4'd3},
    '{OP_T, AC, 16'd5,    16'h0000, 4'd3},
    '{OP_R, AN, 16'h0000, 16'h1239, 4'd3},  // R3 five ticks
    '{OP_W, AP, 16'h0100, 16'h0000, 4'd6},
    '{OP_R, AN, 16'h0000, 16'h1239, 4'd6},  // R6 running: counter kept
    '{OP_R, AP, 16'h0000, 16'h0100, 4'd6},
    '{OP_W, AC, 16'h0080, 16'h0000, 4'd3},
    '{OP_T, AC, 16'd3,    16'h0000, 4'd3},
    '{OP_R, AN, 16'h0000, 16'h1239, 4'd3},  // R3 run=0 holds
    '{OP_W, AC, 16'h0010, 16'h0000, 4'd11},
    '{OP_T, AC, 16'd4,    16'h0000, 4'd11},
    '{OP_R, AN, 16'h0000, 16'h1239, 4'd11}, // R11 mode 00 idle
    '{OP_W, AN, 16'hFFFE, 16'h0000, 4'd5},
    '{OP_W, AC, 16'h0090, 16'h0000, 4'd5},
    '{OP_T, AC, 16'd3,    16'h0000, 4'd5},
    '{OP_R, AN, 16'h0000, 16'h0101, 4'd5},  // R5 reload from preload
    '{OP_R, AF, 16'h0000, 16'h0001, 4'd5},  // R5 flag set
    '{OP_R, AC, 16'h0000, 16'h0090, 4'd5},  // R5 run kept
    '{OP_W, AF, 16'h0001, 16'h0000, 4'd10},
    '{OP_R, AF, 16'h0000, 16'h0001, 4'd10}, // R10 write 1 no effect
    '{OP_W, AF, 16'h0000, 16'h0000, 4'd10},
    '{OP_R, AF, 16'h0000, 16'h0000, 4'd10}, // R10 write 0 clears
    '{OP_W, AC, 16'h0000, 16'h0000, 4'd10}
  };

  logic        clk = 1'b0, rst = 1'b1, tick = 1'b0, ext_pin = 1'b0, int_en = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  evtimer_top u_evtimer_top (
    .clk(clk), .rst(rst), .tick(tick), .ext_pin(ext_pin), .int_en(int_en),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] exp, input string req);
    @(negedge clk); bus_addr = a;
    @(negedge clk); check(req, bus_rdata, exp);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin @(negedge clk); tick = 1'b1; end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic pin(input logic v);
    @(negedge clk); ext_pin = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(5.0 * 50000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    rd(AC, 16'h0000, "R1");
    rd(AP, 16'h0000, "R1");
    rd(AN, 16'h0000, "R1");
    rd(AF, 16'h0000, "R1");
    check("R1", {15'd0, irq}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_W: wr(VECS[i].addr, VECS[i].data);
        OP_R: rd(VECS[i].addr, VECS[i].exp, $sformatf("R%0d vec%0d", VECS[i].req, i));
        default: ticks(int'(VECS[i].data));
      endcase
    end

    // R4 event mode, rising edges
    wr(AN, 16'h0000);
    wr(AC, 16'h0050);
    for (int p = 0; p < 3; p++) begin pin(1'b1); pin(1'b0); end
    ticks(4);
    rd(AN, 16'h0003, "R4 rising");
    // R4 falling edges, rising alone does not count
    wr(AC, 16'h0058);
    pin(1'b1);
    rd(AN, 16'h0003, "R4 opposite edge");
    pin(1'b0);
    rd(AN, 16'h0004, "R4 falling");

    // R7 pulse-width measurement
    wr(AC, 16'h0000);
    wr(AN, 16'h0000);
    wr(AC, 16'h00D0);
    ticks(3);
    rd(AN, 16'h0000, "R7 wait for edge");
    pin(1'b1);
    ticks(7);
    pin(1'b0);
    rd(AN, 16'h0007, "R7 width");
    rd(AC, 16'h00C0, "R7 run cleared");
    ticks(5);
    rd(AN, 16'h0007, "R7 held");

    // R8 further pulses ignored, level at arming ignored
    pin(1'b1); ticks(3); pin(1'b0);
    rd(AN, 16'h0007, "R8 pulse ignored");
    pin(1'b1);
    wr(AC, 16'h00D0);
    ticks(4);
    rd(AN, 16'h0007, "R8 level no start");
    pin(1'b0);
    rd(AC, 16'h00D0, "R8 still armed");
    pin(1'b1); ticks(2); pin(1'b0);
    rd(AN, 16'h0009, "R8 re-armed");

    // R9 overflow inside a measurement
    wr(AN, 16'hFFFE);
    wr(AF, 16'h0000);
    wr(AC, 16'h00D0);
    pin(1'b1); ticks(3); pin(1'b0);
    rd(AN, 16'h0101, "R9 reload");
    rd(AF, 16'h0001, "R9 flag");

    // R10 interrupt gating
    check("R10 gated", {15'd0, irq}, 16'h0000);
    @(negedge clk); int_en = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 enabled", {15'd0, irq}, 16'h0001);
    wr(AF, 16'h0000);
    repeat (2) @(negedge clk);
    check("R10 cleared", {15'd0, irq}, 16'h0000);

    // R1 reset after activity
    wr(AC, 16'h0090);
    do_reset();
    rd(AN, 16'h0000, "R1 re-reset cnt");
    rd(AC, 16'h0000, "R1 re-reset ctrl");
    rd(AP, 16'h0000, "R1 re-reset preload");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule